// File: doc/BRIEF.md
# Per-Pixel Justified Pulse Width Modulator

This block produces one output pulse in every pixel period of a raster output path. A pixel period is a run of 64 ticks of a fast clock, and a one-cycle pixel strobe marks where each period begins. A 6-bit width code sets how many ticks the pulse stays high. Two mode bits place the pulse against the left edge of the period, against the right edge, or centred on its middle tick. A gray-scale or edge-enhancement engine upstream can change the code and the placement on every pixel.

The code and mode are sampled only on strobe clock edges. The first stage holds them while the previous pixel is still being drawn, and they take effect one full period later. An asynchronous set input forces the output high at once, whatever the clock is doing. An asynchronous active-low reset clears every stored code, so the output stays low until a real code has passed through both stages.

Top module: `pixel_pwm`

## Requirements
- R1: For an active code c, the number of high ticks in its 64-tick period is c+1 when c is nonzero and 0 when c is 0. So 0x0F gives 16 ticks, 0x1F gives 32, 0x2F gives 48 and 0x3F gives 64.
- R2: With `single_edge`=1 and `lead_mod`=0 the pulse is left-justified: it is high on ticks 0 to w-1, where w is the high-tick count from R1.
- R3: With `single_edge`=1 and `lead_mod`=1 the pulse is right-justified: it is high on ticks 64-w to 63.
- R4: With `single_edge`=0 the pulse is centred and `lead_mod` has no effect. It is high on ticks 32-floor(w/2) to 32+ceil(w/2)-1, so for an odd w the extra tick falls after tick 32.
- R5: Codes 0x00 (always low) and 0x3F (always high) give the same output for all four mode combinations.
- R6: Tick 0 of a period is the clock cycle that follows a clock edge where `pix_start`=1. The code and mode sampled at that edge shape the period that begins at the next `pix_start` edge, which is a latency of one period.
- R7: Values on `code_in`, `single_edge` and `lead_mod` at clock edges where `pix_start`=0 have no effect. Every period can carry a different code and mode.
- R8: While `set_hi`=1 the output is high at once, without waiting for a clock edge, and it stays high across clock edges. Once `set_hi` returns to 0 the output again follows the active code.
- R9: While `rst_n`=0 the output is low (unless `set_hi` is high), and reset clears both stored codes. After reset ends, the period after the first strobe is all low, and the stored code appears in the period after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, 64 ticks per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_hi | input | 1 | Asynchronous override that forces the output high |
| pix_start | input | 1 | Strobe on the last tick of a period; a new period starts after this edge |
| code_in | input | CODE_W | Pulse width code |
| single_edge | input | 1 | 1: single-edge placement; 0: centred |
| lead_mod | input | 1 | With single_edge=1: 1 right-justified, 0 left-justified |
| pwm_out | output | 1 | Modulated pulse output |

## Verification
On every cycle, the assertions check four things:
- each full period holds exactly the high-tick count that the active code calls for;
- the active registers take the captured values on each strobe edge and hold them between strobes;
- the anchor tick of each placement is high: tick 0 for left, tick 63 for right and tick 32 for centre;
- a full-scale code keeps the output high.

The exact placement of every tick can only be shown by the bench. It sweeps every code against every mode combination and puts unrelated values on the inputs between strobes. The bench also covers set asserted between clock edges, and a reset in the middle of a full-scale period followed by the two-period refill.

// File: rtl/pixel_pwm.sv
module pixel_pwm #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_hi,
  input  logic              pix_start,
  input  logic [CODE_W-1:0] code_in,
  input  logic              single_edge,
  input  logic              lead_mod,
  output logic              pwm_out
);
  localparam int WW    = CODE_W + 1;
  localparam int TICKS = 1 << CODE_W;
  localparam logic [WW-1:0]     TOP  = WW'(TICKS);
  localparam logic [WW-1:0]     MID  = WW'(TICKS / 2);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(TICKS - 1);

  logic [CODE_W-1:0] tick, cap_code, act_code;
  logic              cap_single, cap_lead, act_single, act_lead;
  logic [WW-1:0]     width, lo, hi, tick_w;
  logic              core;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick       <= '0;
      cap_code   <= '0;
      cap_single <= 1'b0;
      cap_lead   <= 1'b0;
      act_code   <= '0;
      act_single <= 1'b0;
      act_lead   <= 1'b0;
    end else begin
      tick <= pix_start ? '0 : tick + CODE_W'(1);
      if (pix_start) begin
        act_code   <= cap_code;
        act_single <= cap_single;
        act_lead   <= cap_lead;
        cap_code   <= code_in;
        cap_single <= single_edge;
        cap_lead   <= lead_mod;
      end
    end
  end

  assign width = (act_code == '0) ? '0 : WW'(act_code) + WW'(1);

  always_comb begin
    if (!act_single)   lo = MID - (width >> 1);
    else if (act_lead) lo = TOP - width;
    else               lo = '0;
    hi = lo + width;
  end

  assign tick_w  = WW'(tick);
  assign core    = (tick_w >= lo) && (tick_w < hi);
  assign pwm_out = set_hi | core;

  logic [WW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= '0;
    else if (pix_start) hi_cnt <= '0;
    else                hi_cnt <= hi_cnt + WW'(core);
  end

  p_full_period_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_start && tick == LAST) |-> (hi_cnt + WW'(core) == width));

  p_left_first_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_single && !act_lead && act_code != '0 && tick == '0) |-> core);

  p_right_last_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_single && act_lead && act_code != '0 && tick == LAST) |-> core);

  p_centre_mid_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_single && act_code != '0 && tick_w == MID) |-> core);

  p_full_code_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == LAST) |-> pwm_out);

  p_capture_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_start |=> (act_code == $past(cap_code) && act_single == $past(cap_single)
                   && act_lead == $past(cap_lead) && tick == '0));

  p_hold_between_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_start |=> ($stable(act_code) && $stable(cap_code) && $stable(act_single)
                    && $stable(act_lead)));

endmodule

// File: tb/pixel_pwm_tb.sv
`timescale 1ns/1ps
module pixel_pwm_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_hi = 1'b0;
  logic       pix_start = 1'b0;
  logic [5:0] code_in = '0;
  logic       single_edge = 1'b0;
  logic       lead_mod = 1'b0;
  logic       pwm_out;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pixel_pwm #(.CODE_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .set_hi(set_hi), .pix_start(pix_start),
    .code_in(code_in), .single_edge(single_edge), .lead_mod(lead_mod),
    .pwm_out(pwm_out)
  );

  function automatic bit exp_bit(int c, bit s, bit l, int t);
    int w, lo;
    w = (c == 0) ? 0 : c + 1;
    if (!s)     lo = 32 - w / 2;
    else if (l) lo = 64 - w;
    else        lo = 0;
    return (t >= lo) && (t < lo + w);
  endfunction

  task automatic check(bit got, bit want, string req);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", req, got, want, $time);
    end
  endtask

  // Called just after a strobe edge: checks the 64 ticks of the running period
  // (showing sc/ss/sl) and strobes nc/ns/nl in at its last tick.
  task automatic run_period(int sc, bit ss, bit sl, int nc, bit ns, bit nl);
    string rq;
    if (sc == 0 || sc == 63) rq = "R5/R1/R6";
    else if (!ss)            rq = "R4/R1/R6";
    else if (sl)             rq = "R3/R1/R6";
    else                     rq = "R2/R1/R6";
    for (int t = 0; t < 64; t++) begin
      @(negedge clk);
      check(pwm_out, exp_bit(sc, ss, sl, t), rq);
      if (t == 63) begin
        pix_start = 1'b1; code_in = 6'(nc); single_edge = ns; lead_mod = nl;
      end else begin
        // R7: unrelated values between strobes must be ignored
        pix_start = 1'b0; code_in = 6'(t) ^ 6'h2A; single_edge = t[0]; lead_mod = t[1];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int sc, nc;
    bit ss, sl, ns, nl;
    repeat (3) @(negedge clk);
    check(pwm_out, 1'b0, "R9 reset low");
    rst_n = 1'b1;

    // R8: asynchronous set while idle
    repeat (5) @(negedge clk);
    check(pwm_out, 1'b0, "R9 idle after reset");
    #1 set_hi = 1'b1;
    #1 check(pwm_out, 1'b1, "R8 set without clock");
    @(negedge clk);
    check(pwm_out, 1'b1, "R8 set held over edge");
    #1 set_hi = 1'b0;
    #1 check(pwm_out, 1'b0, "R8 set released");

    // R1-R7 sweep: every code against every {single_edge,lead_mod}
    @(negedge clk);
    pix_start = 1'b1; code_in = 6'd0; single_edge = 1'b0; lead_mod = 1'b0;
    sc = 0; ss = 0; sl = 0;
    for (int i = 1; i <= 258; i++) begin
      if (i < 256) begin nc = i >> 2; ns = i[1]; nl = i[0]; end
      else begin nc = 63; ns = 1'b1; nl = 1'b0; end
      run_period(sc, ss, sl, nc, ns, nl);
      if (i == 1) begin sc = 0; ss = 0; sl = 0; end
      else begin sc = (i - 1) >> 2; ss = 1'((i - 1) >> 1); sl = 1'(i - 1); end
      if (i >= 257) begin sc = 63; ss = 1'b1; sl = 1'b0; end
    end
    // Now showing 0x3F with 0x3F captured: R9 reset mid-period
    @(negedge clk);
    pix_start = 1'b0;
    check(pwm_out, 1'b1, "R5 full code before reset");
    #1 rst_n = 1'b0;
    #1 check(pwm_out, 1'b0, "R9 async reset forces low");
    repeat (3) begin
      @(negedge clk);
      check(pwm_out, 1'b0, "R9 held in reset");
    end
    rst_n = 1'b1;
    pix_start = 1'b1; code_in = 6'h3F; single_edge = 1'b1; lead_mod = 1'b0;
    run_period(0, 1'b0, 1'b0, 63, 1'b1, 1'b0);   // R9: cleared code drains first
    run_period(63, 1'b1, 1'b0, 0, 1'b0, 1'b0);   // R9: then the stored code shows
    @(negedge clk);
    pix_start = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule